// File: doc/BRIEF.md
# Beat-wrap phase unwrapper

The block takes a stream of raw phase readings and turns it into a continuous time-interval sequence. Each reading is the phase of a measured signal against a reference clock, taken modulo one reference period. When the two oscillators sit slightly apart in frequency, that phase drifts slowly across the period boundary. The raw value then jumps from near the top of its range to near zero, or the other way. The jump is a real beat between the two signals, not a lost count.

The unwrapper keeps a signed count of whole periods. Each accepted reading is compared with the one before it. A drop of more than half a period adds one period to the count, and a rise of more than half a period takes one away. The output is the raw reading plus the count times the period. The raw reading itself is never altered. The count saturates at its signed limits, and a sticky flag for each direction records that saturation happened. The period is a parameter in raw phase units. With 10 MHz clocks and a 10 ps unit, the default of 10000 stands for 100 ns.

Both the input and the output are valid/ready streams. An input is taken on any rising edge where in_valid and in_ready are both high. An output is delivered on any edge where out_valid and out_ready are both high. While out_valid is high and out_ready is low, the output word is held and in_ready goes low, so the whole two-stage pipeline stalls and no sample is lost or repeated. When out_ready stays high, the block accepts a sample on every cycle and presents each result two cycles after it was accepted. Readings are assumed to lie in the range 0 to PERIOD-1.

Top module: `phase_unwrap`

## Requirements
- R1: While reset is applied and right after it is released, out_valid, sat_pos and sat_neg are 0 and in_ready is 1.
- R2: The first sample accepted after reset comes out equal to its raw value, with no period correction.
- R3: If a sample is lower than the sample before it by more than PERIOD/2 (integer division), the period count goes up by one, and this output and every later one carry the extra +PERIOD.
- R4: If a sample is higher than the sample before it by more than PERIOD/2, the period count goes down by one, and later outputs carry -PERIOD.
- R5: A difference between consecutive samples of exactly PERIOD/2 or less in magnitude, in either direction, leaves the period count unchanged.
- R6: out_time is the signed two's-complement value raw + count*PERIOD, and the count keeps its value over any number of wraps within its range. Two consecutive outputs therefore differ by at most PERIOD/2 while no saturation flag is set.
- R7: With out_ready held high, a sample accepted at one clock edge appears on out_valid/out_time after the second following edge, and a new sample can be accepted on every cycle.
- R8: While out_valid is 1 and out_ready is 0, out_valid and out_time hold their values and in_ready is 0. Every accepted sample is delivered exactly once and in order.
- R9: The count saturates at +(2^WRAP_BITS - 1). An upward wrap at that value leaves it there and sets sat_pos. sat_pos then stays at 1 until reset and is visible with the output of the sample that saturated.
- R10: The count saturates at -(2^WRAP_BITS). A downward wrap at that value leaves it there and sets sat_neg, which stays at 1 until reset and is visible with the output of the sample that saturated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A raw phase sample is offered |
| in_ready | output | 1 | The block can take a sample this cycle |
| in_phase | input | PHASE_W | Raw phase, 0 to PERIOD-1 |
| out_valid | output | 1 | out_time holds an unwrapped value |
| out_ready | input | 1 | Downstream takes the output this cycle |
| out_time | output | PHASE_W+WRAP_BITS+2 | Signed unwrapped time interval |
| sat_pos | output | 1 | Sticky: the period count hit its upper limit |
| sat_neg | output | 1 | Sticky: the period count hit its lower limit |

## Verification
A bad count or a bad previous-sample register shows up on out_time as a step of exactly one period. The step appears on the output of the very next sample, two cycles after that sample was accepted, and it persists on every later output. Such a step breaks the half-period continuity between consecutive outputs, and the bench catches it by comparing each output against its own model. Faults in the stall path show up as held data that changes, or as samples that are dropped or repeated. Faults in saturation show up as a count that runs past its limit, or as a flag that sets late or clears.

// File: rtl/unwrap_pkg.sv
package unwrap_pkg;
  // direction of the period correction decided for one sample
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/wrap_detect.sv
module wrap_detect
  import unwrap_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int PERIOD  = 10000
) (
  input  logic [PHASE_W-1:0] cur_phase,
  input  logic [PHASE_W-1:0] last_phase,
  input  logic               have_last,
  output step_e              step
);
  localparam int DW = PHASE_W + 1;
  localparam logic signed [DW-1:0] HALF_S = DW'(PERIOD / 2);

  logic signed [DW-1:0] delta;

  always_comb begin
    delta = signed'({1'b0, cur_phase}) - signed'({1'b0, last_phase});
    step  = STEP_NONE;
    if (have_last) begin
      if (delta < -HALF_S)     step = STEP_UP;  // fell across the top: one period forward
      else if (delta > HALF_S) step = STEP_DN;  // rose across zero: one period back
    end
  end
endmodule

// File: rtl/offset_accum.sv
module offset_accum
  import unwrap_pkg::*;
#(
  parameter int WRAP_BITS = 20,
  localparam int CW = WRAP_BITS + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_en,
  input  step_e                step,
  output logic signed [CW-1:0] cnt_next,
  output logic                 sat_pos,
  output logic                 sat_neg
);
  localparam logic signed [CW-1:0] CNT_MAX = {1'b0, {WRAP_BITS{1'b1}}};
  localparam logic signed [CW-1:0] CNT_MIN = {1'b1, {WRAP_BITS{1'b0}}};
  localparam logic signed [CW-1:0] ONE     = CW'(1);

  logic signed [CW-1:0] cnt_q;
  logic hit_hi, hit_lo;

  always_comb begin
    cnt_next = cnt_q;
    hit_hi   = 1'b0;
    hit_lo   = 1'b0;
    if (step_en) begin
      unique case (step)
        STEP_UP: if (cnt_q == CNT_MAX) hit_hi = 1'b1; else cnt_next = cnt_q + ONE;
        STEP_DN: if (cnt_q == CNT_MIN) hit_lo = 1'b1; else cnt_next = cnt_q - ONE;
        default: cnt_next = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sat_pos <= 1'b0;
      sat_neg <= 1'b0;
    end else if (step_en) begin
      cnt_q <= cnt_next;
      if (hit_hi) sat_pos <= 1'b1;
      if (hit_lo) sat_neg <= 1'b1;
    end
  end
endmodule

// File: rtl/phase_unwrap.sv
module phase_unwrap
  import unwrap_pkg::*;
#(
  parameter int PHASE_W   = 16,
  parameter int PERIOD    = 10000,
  parameter int WRAP_BITS = 20,
  localparam int OUT_W    = PHASE_W + WRAP_BITS + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [PHASE_W-1:0]      in_phase,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_time,
  output logic                    sat_pos,
  output logic                    sat_neg
);
  localparam int CW = WRAP_BITS + 1;
  localparam logic signed [OUT_W-1:0] PERIOD_S = OUT_W'(PERIOD);

  // whole pipeline advances together; stalls only when the output is held
  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // stage 1: wrap detection against the previously accepted sample
  logic [PHASE_W-1:0] last_q;
  logic               have_last_q;
  step_e              step_d;
  logic               s1_valid;
  logic [PHASE_W-1:0] s1_phase;
  step_e              s1_step;

  wrap_detect #(.PHASE_W(PHASE_W), .PERIOD(PERIOD)) u_detect (
    .cur_phase (in_phase),
    .last_phase(last_q),
    .have_last (have_last_q),
    .step      (step_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q      <= '0;
      have_last_q <= 1'b0;
      s1_valid    <= 1'b0;
      s1_phase    <= '0;
      s1_step     <= STEP_NONE;
    end else if (adv) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_phase    <= in_phase;
        s1_step     <= step_d;
        last_q      <= in_phase;
        have_last_q <= 1'b1;
      end
    end
  end

  // stage 2: period count update and reconstruction
  logic signed [CW-1:0]    cnt_next;
  logic signed [OUT_W-1:0] cnt_ext, shift, raw_ext;

  offset_accum #(.WRAP_BITS(WRAP_BITS)) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (adv && s1_valid),
    .step    (s1_step),
    .cnt_next(cnt_next),
    .sat_pos (sat_pos),
    .sat_neg (sat_neg)
  );

  always_comb begin
    cnt_ext = OUT_W'(cnt_next);
    shift   = cnt_ext * PERIOD_S;
    raw_ext = signed'({{(OUT_W-PHASE_W){1'b0}}, s1_phase});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_time  <= '0;
    end else if (adv) begin
      out_valid <= s1_valid;
      if (s1_valid) out_time <= raw_ext + shift;
    end
  end
endmodule

// File: rtl/phase_unwrap_chk.sv
module phase_unwrap_chk #(
  parameter int OUT_W  = 38,
  parameter int PERIOD = 10000
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [OUT_W-1:0] out_time,
  input logic                    sat_pos,
  input logic                    sat_neg
);
  localparam logic signed [OUT_W:0] HALF_S = (OUT_W+1)'(PERIOD / 2);

  logic signed [OUT_W-1:0] prev_out;
  logic                    have_prev;
  logic signed [OUT_W:0]   jump;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_out  <= '0;
      have_prev <= 1'b0;
    end else if (out_valid && out_ready) begin
      prev_out  <= out_time;
      have_prev <= 1'b1;
    end
  end

  assign jump = (OUT_W+1)'(out_time) - (OUT_W+1)'(prev_out);

  // R6
  continuity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && have_prev && !sat_pos && !sat_neg)
      |-> (jump <= HALF_S && jump >= -HALF_S));

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready, 2) && $past(out_ready)) |-> out_valid);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_time)));

  // R8
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  sat_pos_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_pos |=> sat_pos);

  // R10
  sat_neg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_neg |=> sat_neg);
endmodule

bind phase_unwrap phase_unwrap_chk #(.OUT_W(OUT_W), .PERIOD(PERIOD)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_time (out_time),
  .sat_pos  (sat_pos),
  .sat_neg  (sat_neg)
);

// File: tb/phase_unwrap_test.sv
module phase_unwrap_test;
  localparam int PW = 8, PER = 100, WB = 3, OW = PW + WB + 2;
  localparam int KMAX = (1 << WB) - 1, KMIN = -(1 << WB);
  localparam int NV = 12;
  // raw phase, expected unwrapped output
  localparam int VEC [NV][2] = '{
    '{10, 10}, '{50, 50}, '{95, 95}, '{5, 105}, '{40, 140}, '{90, 190},
    '{99, 199}, '{0, 200}, '{98, 198}, '{3, 203}, '{60, 160}, '{10, 110}};

  logic clk = 0, rst_n = 0, in_valid = 0, out_ready = 1;
  logic [PW-1:0] in_phase = '0;
  logic in_ready, out_valid, sat_pos, sat_neg;
  logic signed [OW-1:0] out_time;

  int checks = 0, failures = 0, cyc = 0;
  int q_t[512], q_p[512], q_n[512];
  int wr = 0, rd = 0;
  int m_prev, m_k, m_first, m_sp, m_sn;
  bit bp_mode = 0, mon_on = 0;
  bit was_stall = 0;
  int held_t;

  phase_unwrap #(.PHASE_W(PW), .PERIOD(PER), .WRAP_BITS(WB)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_phase(in_phase), .out_valid(out_valid), .out_ready(out_ready),
    .out_time(out_time), .sat_pos(sat_pos), .sat_neg(sat_neg));

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // downstream ready pattern
  always @(negedge clk) out_ready = bp_mode ? (cyc[0] ^ cyc[2]) : 1'b1;

  // output monitor, sampled mid-cycle
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      if (was_stall)
        check(out_valid && int'(out_time) == held_t, "R8 hold", int'(out_time), held_t);
      if (out_valid && out_ready) begin
        if (rd == wr) check(0, "R8 extra output", int'(out_time), -1);
        else begin
          check(int'(out_time) == q_t[rd], "R6 value", int'(out_time), q_t[rd]);
          check(sat_pos == q_p[rd], "R9 flag", int'(sat_pos), q_p[rd]);
          check(sat_neg == q_n[rd], "R10 flag", int'(sat_neg), q_n[rd]);
          rd++;
        end
      end
      was_stall = out_valid && !out_ready;
      held_t = int'(out_time);
      if (was_stall) check(!in_ready, "R8 in_ready", int'(in_ready), 0);
    end
  end

  // reference behaviour from the requirements
  function automatic int model(input int p);
    if (m_first) m_first = 0;
    else if (m_prev - p > PER / 2) begin
      if (m_k == KMAX) m_sp = 1; else m_k++;
    end else if (p - m_prev > PER / 2) begin
      if (m_k == KMIN) m_sn = 1; else m_k--;
    end
    m_prev = p;
    return p + m_k * PER;
  endfunction

  task automatic send(input int p, input int exp, input bit use_exp);
    int e;
    in_valid = 1;
    in_phase = PW'(p);
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    e = model(p);
    q_t[wr] = use_exp ? exp : e;
    q_p[wr] = m_sp;
    q_n[wr] = m_sn;
    wr++;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic drain();
    bp_mode = 0;
    repeat (6) @(negedge clk);
    check(rd == wr, "R8 delivered", rd, wr);
  endtask

  task automatic do_reset();
    mon_on = 0;
    @(negedge clk);
    rst_n = 0;
    in_valid = 0;
    repeat (2) @(negedge clk);
    check(!out_valid && !sat_pos && !sat_neg, "R1 in reset", int'({out_valid, sat_pos, sat_neg}), 0);
    rst_n = 1;
    #1;
    check(in_ready && !out_valid, "R1 after release", int'({in_ready, out_valid}), 2);
    m_first = 1; m_k = 0; m_prev = 0; m_sp = 0; m_sn = 0;
    rd = 0; wr = 0; was_stall = 0;
    @(negedge clk);
    mon_on = 1;
  endtask

  initial begin
    do_reset();
    // R2 R3 R4 R5 R6: table of wraps and half-period boundaries, back to back
    for (int i = 0; i < NV; i++) send(VEC[i][0], VEC[i][1], 1);
    drain();

    // R7: latency of a single sample
    do_reset();
    mon_on = 0;
    in_valid = 1; in_phase = 8'd33;
    @(negedge clk); in_valid = 0;
    #1 check(!out_valid, "R7 one edge", int'(out_valid), 0);
    @(negedge clk);
    #1 check(out_valid && int'(out_time) == 33, "R7 two edges / R2", int'(out_time), 33);

    // R8: random back-pressure with wraps both ways
    do_reset();
    bp_mode = 1;
    for (int i = 0; i < 24; i++) send((i < 12) ? (i * 37) % PER : ((48 - i) * 37) % PER, 0, 0);
    drain();

    // R9: steady upward wraps until the count saturates
    do_reset();
    for (int i = 0; i < 30; i++) send((i * 40) % PER, 0, 0);
    drain();
    check(sat_pos && !sat_neg, "R9 sticky", int'({sat_pos, sat_neg}), 2);
    check(int'(out_time) == 60 + KMAX * PER, "R9 clamped", int'(out_time), 60 + KMAX * PER);

    // R10: steady downward wraps until the count saturates
    do_reset();
    for (int i = 0; i < 30; i++) send(((30 - i) * 40) % PER, 0, 0);
    drain();
    check(sat_neg && !sat_pos, "R10 sticky", int'({sat_pos, sat_neg}), 1);
    check(int'(out_time) == 40 + KMIN * PER, "R10 clamped", int'(out_time), 40 + KMIN * PER);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule